// File: doc/BRIEF.md
# Random allocation tag generator

This block picks a 4-bit colour tag for a pointer, for use in tagged-memory schemes where each pointer carries a small key that must match the key of the memory it touches. On each request it takes a start tag and a 16-bit seed from the caller-held state word. It advances the seed four times through a 16-bit linear feedback shift register and gathers the four feedback bits into a step count. It then walks forward through the sixteen tag values from the start tag, one step per unit of the count, and jumps over any value blocked by the exclusion mask.

The exclusion mask merges a per-request mask with a global mask carried in a control word. The control word also holds a reseed enable. When that enable is set and the seed is zero, a fixed nonzero constant stands in for an entropy source. The result is the incoming pointer with its tag field overwritten, plus a new state word that the caller stores and hands back on the next request. Results are registered and appear one cycle after the request.

The control is a two-state machine. `RG_IDLE` means no result is being presented. `RG_DONE` means a result is valid this cycle. The transition `req_valid=1` moves either state to `RG_DONE`. The transition `req_valid=0` moves either state to `RG_IDLE`. Back-to-back requests therefore keep the machine in `RG_DONE`, with one result per cycle.

Top module: `rand_tag_gen`

## Requirements
- R1: `res_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, and is 0 otherwise. It is 0 after reset, when `res_ptr` and `st_out` are also 0.
- R2: `res_ptr` equals the requested pointer with bits [59:56] replaced by the chosen tag. All other bits are unchanged.
- R3: The effective exclusion mask is `req_excl | ctrl_word[15:0]`. Bit n set means tag value n is blocked.
- R4: The seed is `st_in[23:8]`. Each of four steps computes fb = s[5]^s[3]^s[2]^s[0] and sets s = {fb, s[15:1]}. The fb of step i (i = 0..3) becomes bit i of the step count.
- R5: When the effective mask is 16'hFFFF, the tag is 0. The seed still advances as in R4.
- R6: For a nonzero step count, starting from the start tag `st_in[3:0]`, each unit of the count moves to the next value modulo 16 that is not blocked. The start value itself is never tested.
- R7: For a zero step count, the tag is the first non-blocked value at or after the start tag, modulo 16. An unblocked start tag is kept as it is.
- R8: When `ctrl_word[16]` is 1 and the seed is 0, the constant RESEED_VAL (default 16'hACE1) replaces the seed before stepping. The substitution does not happen when the enable is 0 or the seed is nonzero.
- R9: After a request, `st_out` = {new seed in [23:8], 4'b0 in [7:4], tag in [3:0]}. `st_out` holds its value in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ptr | input | 64 | Pointer to be tagged |
| req_excl | input | 16 | Per-request exclusion mask |
| ctrl_word | input | 17 | [15:0] global exclusion mask, [16] reseed enable |
| st_in | input | 24 | Current state: [23:8] seed, [3:0] start tag |
| res_valid | output | 1 | Result valid |
| res_ptr | output | 64 | Pointer with new tag in [59:56] |
| st_out | output | 24 | Updated state word |

## Verification
The hardest path to reach from the ports is a zero step count, because the count comes out of the shift register rather than from an input. The stimulus reaches it by supplying a zero seed with the reseed enable clear, so all four feedback bits are zero. The start tag is then blocked, so that the forward search from the start tag (rather than a step walk) is visible. The all-blocked case is reached by splitting the sixteen blocked bits between the request mask and the global mask, which also checks the merge. Wrap-around from tag 15 to tag 0 past a blocked value 0 is driven directly. Back-to-back requests with changing seeds are driven to check that one result comes out per cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int TAG_W    = 4;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int SEED_W   = 16;
    localparam int STATE_W  = 8 + SEED_W;

    typedef enum logic [0:0] {
        RG_IDLE = 1'b0,
        RG_DONE = 1'b1
    } rg_state_e;

    // Next unblocked value strictly after cur, modulo NUM_TAGS.
    function automatic logic [TAG_W-1:0] tag_after(
        input logic [TAG_W-1:0]    cur,
        input logic [NUM_TAGS-1:0] mask
    );
        logic [TAG_W-1:0] r;
        r = cur;
        for (int i = NUM_TAGS; i >= 1; i--) begin
            logic [TAG_W-1:0] c;
            c = TAG_W'(int'(cur) + i);
            if (!mask[c]) r = c;
        end
        return r;
    endfunction

    // First unblocked value at or after cur, modulo NUM_TAGS.
    function automatic logic [TAG_W-1:0] tag_settle(
        input logic [TAG_W-1:0]    cur,
        input logic [NUM_TAGS-1:0] mask
    );
        logic [TAG_W-1:0] r;
        r = cur;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            logic [TAG_W-1:0] c;
            c = TAG_W'(int'(cur) + i);
            if (!mask[c]) r = c;
        end
        return r;
    endfunction
endpackage

// File: rtl/rtg_lfsr.sv
module rtg_lfsr
    import rtg_pkg::*;
#(
    parameter int STEPS = TAG_W
) (
    input  logic [SEED_W-1:0] seed_in,
    output logic [SEED_W-1:0] seed_out,
    output logic [STEPS-1:0]  step_cnt
);
    logic [SEED_W-1:0] chain [0:STEPS];

    assign chain[0] = seed_in;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        logic fb;
        assign fb          = chain[k][5] ^ chain[k][3] ^ chain[k][2] ^ chain[k][0];
        assign chain[k+1]  = {fb, chain[k][SEED_W-1:1]};
        assign step_cnt[k] = fb;
    end

    assign seed_out = chain[STEPS];
endmodule

// File: rtl/rtg_walk.sv
module rtg_walk
    import rtg_pkg::*;
(
    input  logic [TAG_W-1:0]    start_tag,
    input  logic [TAG_W-1:0]    step_cnt,
    input  logic [NUM_TAGS-1:0] excl_mask,
    output logic [TAG_W-1:0]    tag_out
);
    localparam int STAGES = NUM_TAGS - 1;

    logic [TAG_W-1:0] hop [0:STAGES];
    logic             all_blocked;

    assign hop[0]      = start_tag;
    assign all_blocked = &excl_mask;

    for (genvar k = 1; k <= STAGES; k++) begin : g_hop
        assign hop[k] = (step_cnt >= TAG_W'(k)) ? tag_after(hop[k-1], excl_mask)
                                                : hop[k-1];
    end

    always_comb begin
        if (all_blocked)
            tag_out = '0;
        else if (step_cnt == '0)
            tag_out = tag_settle(start_tag, excl_mask);
        else
            tag_out = hop[STAGES];
    end
endmodule

// File: rtl/rand_tag_gen.sv
module rand_tag_gen
    import rtg_pkg::*;
#(
    parameter int                PTR_W      = 64,
    parameter int                TAG_LSB    = 56,
    parameter logic [SEED_W-1:0] RESEED_VAL = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PTR_W-1:0]    req_ptr,
    input  logic [NUM_TAGS-1:0] req_excl,
    input  logic [NUM_TAGS:0]   ctrl_word,
    input  logic [STATE_W-1:0]  st_in,
    output logic                res_valid,
    output logic [PTR_W-1:0]    res_ptr,
    output logic [STATE_W-1:0]  st_out
);
    localparam int SEED_LSB = STATE_W - SEED_W;

    rg_state_e state_q, state_d;

    logic [NUM_TAGS-1:0] eff_mask;
    logic [NUM_TAGS-1:0] mask_q;
    logic [SEED_W-1:0]   seed_src;
    logic [SEED_W-1:0]   seed_new;
    logic [TAG_W-1:0]    step_cnt;
    logic [TAG_W-1:0]    tag_new;
    logic [PTR_W-1:0]    ptr_new;

    assign eff_mask = req_excl | ctrl_word[NUM_TAGS-1:0];

    always_comb begin
        seed_src = st_in[STATE_W-1:SEED_LSB];
        if (ctrl_word[NUM_TAGS] && (seed_src == '0))
            seed_src = RESEED_VAL;
    end

    rtg_lfsr #(.STEPS(TAG_W)) u_lfsr (
        .seed_in  (seed_src),
        .seed_out (seed_new),
        .step_cnt (step_cnt)
    );

    rtg_walk u_walk (
        .start_tag (st_in[TAG_W-1:0]),
        .step_cnt  (step_cnt),
        .excl_mask (eff_mask),
        .tag_out   (tag_new)
    );

    always_comb begin
        ptr_new = req_ptr;
        ptr_new[TAG_LSB +: TAG_W] = tag_new;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_IDLE: state_d = req_valid ? RG_DONE : RG_IDLE;
            RG_DONE: state_d = req_valid ? RG_DONE : RG_IDLE;
            default: state_d = RG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RG_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_ptr <= '0;
            st_out  <= '0;
            mask_q  <= '0;
        end else if (req_valid) begin
            res_ptr <= ptr_new;
            st_out  <= {seed_new, {(SEED_LSB-TAG_W){1'b0}}, tag_new};
            mask_q  <= eff_mask;
        end
    end

    assign res_valid = (state_q == RG_DONE);

    assert_valid_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_quiet_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    assert_ptr_bits_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((res_ptr ^ $past(req_ptr)) &
                       ~({{(PTR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB)) == '0);

    assert_tag_not_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(&mask_q)) |-> !mask_q[res_ptr[TAG_LSB +: TAG_W]]);

    assert_all_blocked_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (&mask_q)) |-> (res_ptr[TAG_LSB +: TAG_W] == '0));

    assert_state_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(st_out));

    assert_state_tag_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (st_out[TAG_W-1:0] == res_ptr[TAG_LSB +: TAG_W]));
endmodule

// File: tb/tb_rand_tag_gen.sv
module tb_rand_tag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [15:0] req_excl = '0;
    logic [16:0] ctrl_word = '0;
    logic [23:0] st_in = '0;
    logic        res_valid;
    logic [63:0] res_ptr;
    logic [23:0] st_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] ptr;
        logic [23:0] st;
        int          at;
        string       tag;
    } item_t;

    item_t sb [$];
    logic [23:0] last_st = '0;

    rand_tag_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
        .req_excl(req_excl), .ctrl_word(ctrl_word), .st_in(st_in),
        .res_valid(res_valid), .res_ptr(res_ptr), .st_out(st_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic logic [3:0] model_tag(input logic [3:0] start,
                                             input logic [3:0] cnt,
                                             input logic [15:0] m);
        logic [3:0] t;
        t = start;
        if (m == 16'hFFFF) return 4'h0;
        if (cnt == 0) begin
            for (int g = 0; g < 16 && m[t]; g++) t = t + 4'd1;
        end else begin
            for (int u = 0; u < cnt; u++) begin
                t = t + 4'd1;
                for (int g = 0; g < 16 && m[t]; g++) t = t + 4'd1;
            end
        end
        return t;
    endfunction

    task automatic send(input logic [63:0] p, input logic [15:0] ex,
                        input logic [16:0] cw, input logic [23:0] st,
                        input string tag);
        logic [15:0] s;
        logic [3:0]  cnt;
        logic [3:0]  t;
        logic [15:0] m;
        item_t it;
        s = st[23:8];
        if (cw[16] && s == 16'h0) s = 16'hACE1;
        for (int i = 0; i < 4; i++) begin
            logic fb;
            fb = s[5] ^ s[3] ^ s[2] ^ s[0];
            s = {fb, s[15:1]};
            cnt[i] = fb;
        end
        m = ex | cw[15:0];
        t = model_tag(st[3:0], cnt, m);
        @(negedge clk);
        req_valid = 1'b1; req_ptr = p; req_excl = ex; ctrl_word = cw; st_in = st;
        it.ptr = {p[63:60], t, p[55:0]};
        it.st  = {s, 4'h0, t};
        it.at  = cyc;
        it.tag = tag;
        sb.push_back(it);
        last_st = it.st;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_excl = 16'hFFFF;
            st_in = 24'hFFFFFF;
        end
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R1 unexpected result", 64'(res_valid), 64'h0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        check(cyc == it.at + 1, {"R1 latency ", it.tag},
                              64'(cyc), 64'(it.at + 1));
                        check(res_ptr == it.ptr, {"R2 pointer ", it.tag}, res_ptr, it.ptr);
                        check(st_out == it.st, {"R9 state ", it.tag},
                              64'(st_out), 64'(it.st));
                    end
                end else if (sb.size() != 0 && cyc > sb[0].at + 1) begin
                    check(1'b0, {"R1 missing result ", sb[0].tag}, 64'h0, 64'h1);
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] st;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0, "R1 reset valid", 64'(res_valid), 64'h0);
        check(res_ptr == 64'h0, "R1 reset pointer", res_ptr, 64'h0);
        check(st_out == 24'h0, "R1 reset state", 64'(st_out), 64'h0);

        // R4 R6 plain stepping, no exclusions
        send(64'h0123_4567_89AB_CDEF, 16'h0000, 17'h0, {16'h1234, 4'h0, 4'h5}, "R4 R6 plain");
        idle(2);
        // R3 merge of two masks
        send(64'hFFFF_0000_1111_2222, 16'h00F0, 17'h00F0F, {16'hBEEF, 4'h0, 4'h2}, "R3 merged");
        idle(1);
        // R5 all blocked, split across the two masks; field was F
        send(64'hAFFF_FFFF_FFFF_FFFF, 16'hFF00, 17'h000FF, {16'h5A5A, 4'h0, 4'h7}, "R5 all blocked");
        idle(1);
        // R7 zero step count: seed 0, reseed off, start 3 blocked with 4 -> 5
        send(64'h1000_0000_0000_0040, 16'h0018, 17'h0, {16'h0000, 4'h0, 4'h3}, "R7 settle");
        idle(1);
        // R7 unblocked start kept
        send(64'h2000_0000_0000_0000, 16'h0000, 17'h0, {16'h0000, 4'h0, 4'h9}, "R7 keep");
        idle(1);
        // R8 reseed with zero seed
        send(64'h3000_0000_0000_0001, 16'h0000, 17'h10000, {16'h0000, 4'h0, 4'h0}, "R8 reseed");
        idle(1);
        // R8 enable set but seed nonzero: no substitution
        send(64'h4000_0000_0000_0002, 16'h0000, 17'h10000, {16'h0001, 4'h0, 4'h0}, "R8 no reseed");
        idle(1);
        // R6 wrap past blocked 0 from 15
        send(64'h5000_0000_0000_0003, 16'h0001, 17'h0, {16'hACE1, 4'h0, 4'hF}, "R6 wrap");
        idle(1);
        // R6 sparse mask, only two tags allowed
        send(64'h6000_0000_0000_0004, 16'hEFFE, 17'h0, {16'h9E37, 4'h0, 4'hC}, "R6 sparse");
        idle(1);
        // R1 back-to-back with state chained from model
        st = {16'h7F31, 4'h0, 4'h1};
        for (int k = 0; k < 8; k++) begin
            send(64'h7000_0000_0000_0000 + 64'(k), 16'(16'h0101 << (k % 8)), 17'h0, st,
                 "R1 back-to-back");
            st = last_st;
        end
        idle(4);
        // R9 state held without requests
        check(st_out == last_st, "R9 hold", 64'(st_out), 64'(last_st));
        check(res_valid == 1'b0, "R1 idle valid", 64'(res_valid), 64'h0);
        check(sb.size() == 0, "R1 all results seen", 64'(sb.size()), 64'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule